// File: doc/BRIEF.md
# Parallel Port Control Microsequencer

This block runs short control programs against a parallel port register set without help from software. A program of fixed 32-bit microinstructions is written into a local program memory through a write port. A start pulse sets the program counter to zero. The engine then executes one instruction per clock until a return instruction ends the run. Some instructions need more than one clock, such as delays, repeated buffer transfers and timed trigger sequences.

The engine holds a program counter, an 8-bit loop/branch register, a byte-buffer pointer and one saved return address. With these it can write or modify the data and control registers, sample the status inputs and data lines into an external byte buffer, wait a number of microseconds, loop with a decrement-and-branch, branch on status bit patterns, and enter one subroutine level. A run always ends with a single-cycle done pulse that carries an 8-bit result code. An error flag marks a run that was stopped by an illegal instruction.

Top module: `pport_useq`

## Requirements
- R1: `start` is accepted only while `busy` is low. It clears the program counter, branch register, buffer pointer, subroutine flag and `err`, and `busy` rises on the next clock. A `start` while busy has no effect on execution.
- R2: Instruction fields are opcode [31:27], register select [26:24], A [23:16], B [15:8] and C [7:0]. The register selects are 0 = data, 1 = status, 2 = control, and 3..7 = reserved. Reserved selects read as 0 and ignore writes.
- R3: Opcode 2 (fetch) writes (selected register AND A) to the buffer at the pointer in its own execute cycle and leaves the pointer unchanged. Reading the data register returns `pd_in`.
- R4: Opcode 3 (modify) sets the register to (current | A) & ~B on data or control. On status or reserved selects it changes nothing.
- R5: Opcode 4 (write) loads A into the data or control register.
- R6: Opcode 5 (delay) with C > 0 holds execution for C×TICKS clocks after its execute cycle. C = 0 costs only its execute cycle.
- R7: Opcode 6 loads C into the branch register. Opcode 7 decrements it and branches when the 8-bit two's-complement result is greater than zero. Every branch target is (address of this instruction + 1 + signed C), modulo the program depth.
- R8: Opcode 8 branches when any status bit selected by A is 1. Opcode 9 branches when any status bit selected by A is 0. Opcode 14 branches when all A bits are 1 and all B bits are 0.
- R9: Opcode 10 (return) ends the run. `done` is high for exactly one clock with `ret_code` = C and `err` = 0, and `busy` falls in the same clock.
- R10: Opcode 16 (call) saves the next address and jumps to absolute address C. Opcode 15 returns to the saved address. A call inside a subroutine, or a subroutine return outside one, ends the run with `done`, `err` = 1 and `ret_code` = 0.
- R11: Opcodes 0, 1, 11, 13 and 20..31 end the run the same way as an error in R10.
- R12: Opcode 12 loads C into the buffer pointer. Opcode 17 writes buffer bytes into the selected register, and opcode 18 stores (register AND B) into the buffer. Each of these transfers A bytes, one per clock after the execute cycle, and the pointer steps by one after each byte. A = 0 does nothing.
- R13: Opcode 19 (trigger) runs A pairs read from the buffer at the pointer. For each pair it writes the first byte into the selected register, then waits the second byte times TICKS clocks. The pointer advances by two per pair.
- R14: `pd_oe` is the inverse of control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run at address 0 |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | PAW | Program memory write address |
| prog_data | input | 32 | Microinstruction to store |
| stat_in | input | 8 | Status inputs |
| pd_in | input | 8 | Sensed data lines |
| pd_out | output | 8 | Data register |
| pd_oe | output | 1 | Data line drive enable |
| ctl_out | output | 8 | Control register |
| buf_addr | output | BAW | Buffer byte address (pointer) |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer byte at `buf_addr`, combinational |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |
| err | output | 1 | Last run stopped on an illegal instruction |
| ret_code | output | 8 | Result code of the last run |

## Verification
Two events can land on the same clock: the end of one run and the start of the next. The done pulse is high in the first idle clock, so a `start` held during that clock must be accepted. The bench waits until it sees `done` and raises `start` in that same clock. The per-clock model then expects the second run's single instruction and its done pulse exactly two clocks later. A second overlap is tested by pulsing `start` in the middle of a delay, which must leave the cycle-exact trace unchanged.

// File: rtl/pport_useq.sv
module pport_useq #(
  parameter int PDEPTH = 64,
  parameter int TICKS  = 4,
  parameter int BAW    = 8,
  localparam int PAW   = $clog2(PDEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           prog_we,
  input  logic [PAW-1:0] prog_addr,
  input  logic [31:0]    prog_data,
  input  logic [7:0]     stat_in,
  input  logic [7:0]     pd_in,
  output logic [7:0]     pd_out,
  output logic           pd_oe,
  output logic [7:0]     ctl_out,
  output logic [BAW-1:0] buf_addr,
  output logic           buf_we,
  output logic [7:0]     buf_wdata,
  input  logic [7:0]     buf_rdata,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [7:0]     ret_code
);
  localparam int DW = 8 + $clog2(TICKS + 1);

  localparam logic [4:0] OP_FETCH = 5'd2,  OP_MOD   = 5'd3,  OP_WR    = 5'd4,
                         OP_DLY   = 5'd5,  OP_SETB  = 5'd6,  OP_DBR   = 5'd7,
                         OP_BSET  = 5'd8,  OP_BCLR  = 5'd9,  OP_RET   = 5'd10,
                         OP_PTR   = 5'd12, OP_BSTAT = 5'd14, OP_SRET  = 5'd15,
                         OP_CALL  = 5'd16, OP_WRP   = 5'd17, OP_FETP  = 5'd18,
                         OP_TRIG  = 5'd19;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_WAIT, S_REP, S_TWR, S_TDL} st_t;

  logic [31:0]    pmem [PDEPTH];
  st_t            st;
  logic [PAW-1:0] pc, rpc;
  logic           in_sub, trig_m;
  logic [7:0]     br, cnt;
  logic [BAW-1:0] ptr;
  logic [DW-1:0]  dcnt;
  logic [31:0]    ir;

  always_ff @(posedge clk)
    if (prog_we) pmem[prog_addr] <= prog_data;

  wire [31:0] ins  = (st == S_RUN) ? pmem[pc] : ir;
  wire [4:0]  op   = ins[31:27];
  wire [2:0]  rsel = ins[26:24];
  wire [7:0]  fa   = ins[23:16];
  wire [7:0]  fb   = ins[15:8];
  wire [7:0]  fc   = ins[7:0];

  wire [7:0]     br_dec = br - 8'd1;
  wire [PAW-1:0] pc_inc = pc + PAW'(1);
  wire [PAW-1:0] pc_br  = pc_inc + PAW'($signed(fc));

  logic [7:0] rval;
  always_comb
    case (rsel)
      3'd0:    rval = pd_in;
      3'd1:    rval = stat_in;
      3'd2:    rval = ctl_out;
      default: rval = 8'h00;
    endcase

  logic take;
  always_comb
    case (op)
      OP_DBR:   take = $signed(br_dec) > 8'sd0;
      OP_BSET:  take = |(stat_in & fa);
      OP_BCLR:  take = |(~stat_in & fa);
      OP_BSTAT: take = ((stat_in & fa) == fa) && ((stat_in & fb) == 8'h00);
      default:  take = 1'b0;
    endcase

  logic known;
  always_comb
    case (op)
      OP_FETCH, OP_MOD, OP_WR, OP_DLY, OP_SETB, OP_DBR, OP_BSET, OP_BCLR, OP_RET,
      OP_PTR, OP_BSTAT, OP_SRET, OP_CALL, OP_WRP, OP_FETP, OP_TRIG: known = 1'b1;
      default: known = 1'b0;
    endcase

  wire fault = (st == S_RUN) &&
               (!known || (op == OP_SRET && !in_sub) || (op == OP_CALL && in_sub));

  assign buf_addr  = ptr;
  assign buf_we    = (st == S_RUN && op == OP_FETCH) || (st == S_REP && op == OP_FETP);
  assign buf_wdata = rval & ((op == OP_FETCH) ? fa : fb);
  assign busy      = (st != S_IDLE);
  assign pd_oe     = ~ctl_out[5];

  wire [7:0] base   = (rsel == 3'd2) ? ctl_out : pd_out;
  wire       wr_en  = (st == S_RUN && (op == OP_MOD || op == OP_WR)) ||
                      (st == S_REP && op == OP_WRP) || (st == S_TWR);
  wire [7:0] wr_val = (st != S_RUN) ? buf_rdata :
                      (op == OP_MOD) ? ((base | fa) & ~fb) : fa;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pd_out  <= '0;
      ctl_out <= '0;
    end else if (wr_en) begin
      if (rsel == 3'd0) pd_out  <= wr_val;
      if (rsel == 3'd2) ctl_out <= wr_val;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; rpc <= '0; in_sub <= 1'b0; trig_m <= 1'b0;
      br <= '0; cnt <= '0; ptr <= '0; dcnt <= '0; ir <= '0;
      done <= 1'b0; err <= 1'b0; ret_code <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            st <= S_RUN; pc <= '0; in_sub <= 1'b0; err <= 1'b0;
            br <= '0; ptr <= '0;
          end
        S_RUN: begin
          ir <= ins;
          pc <= pc_inc;
          if (fault) begin
            done <= 1'b1; err <= 1'b1; ret_code <= '0; st <= S_IDLE;
          end else
            case (op)
              OP_DLY:
                if (fc != 8'd0) begin
                  dcnt <= DW'(fc) * DW'(TICKS); trig_m <= 1'b0; st <= S_WAIT;
                end
              OP_SETB: br <= fc;
              OP_DBR: begin
                br <= br_dec;
                if (take) pc <= pc_br;
              end
              OP_BSET, OP_BCLR, OP_BSTAT: if (take) pc <= pc_br;
              OP_RET: begin
                done <= 1'b1; ret_code <= fc; st <= S_IDLE;
              end
              OP_PTR:  ptr <= BAW'(fc);
              OP_SRET: begin
                pc <= rpc; in_sub <= 1'b0;
              end
              OP_CALL: begin
                rpc <= pc_inc; pc <= fc[PAW-1:0]; in_sub <= 1'b1;
              end
              OP_WRP, OP_FETP:
                if (fa != 8'd0) begin cnt <= fa; st <= S_REP; end
              OP_TRIG:
                if (fa != 8'd0) begin cnt <= fa; st <= S_TWR; end
              default: ;
            endcase
        end
        S_WAIT:
          if (dcnt == DW'(1)) begin
            if (trig_m && cnt != 8'd1) begin cnt <= cnt - 8'd1; st <= S_TWR; end
            else st <= S_RUN;
          end else dcnt <= dcnt - DW'(1);
        S_REP: begin
          ptr <= ptr + BAW'(1);
          if (cnt == 8'd1) st <= S_RUN;
          else cnt <= cnt - 8'd1;
        end
        S_TWR: begin
          ptr <= ptr + BAW'(1); st <= S_TDL;
        end
        S_TDL: begin
          ptr <= ptr + BAW'(1);
          if (buf_rdata != 8'd0) begin
            dcnt <= DW'(buf_rdata) * DW'(TICKS); trig_m <= 1'b1; st <= S_WAIT;
          end else if (cnt == 8'd1) st <= S_RUN;
          else begin cnt <= cnt - 8'd1; st <= S_TWR; end
        end
        default: st <= S_IDLE;
      endcase
    end

  AST_START_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (st == S_RUN && pc == '0)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_WAIT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && dcnt > DW'(1)) |=> (st == S_WAIT && dcnt == $past(dcnt) - DW'(1))); // R6
  AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && in_sub && op == OP_CALL) |=> (done && err)); // R10
  AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && op == 5'd0) |=> (done && err && ret_code == 8'd0)); // R11
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REP) |=> (ptr == $past(ptr) + BAW'(1))); // R12
endmodule

// File: tb/sim_pport_useq.sv
module sim_pport_useq;
  localparam int PDEPTH = 64, TICKS = 4, BAW = 8, PAW = 6;

  logic clk = 0, rst_n = 0, start = 0, prog_we = 0;
  logic [PAW-1:0] prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [7:0] stat_in = 8'h5C, pd_in = 8'h3C;
  logic [7:0] pd_out, ctl_out, buf_wdata, ret_code;
  logic [BAW-1:0] buf_addr;
  logic pd_oe, buf_we, busy, done, err;
  logic [7:0] bmem [256];

  always #2 clk = ~clk;

  pport_useq #(.PDEPTH(PDEPTH), .TICKS(TICKS), .BAW(BAW)) u0 (
    .clk, .rst_n, .start, .prog_we, .prog_addr, .prog_data, .stat_in, .pd_in,
    .pd_out, .pd_oe, .ctl_out, .buf_addr, .buf_we, .buf_wdata,
    .buf_rdata(bmem[buf_addr]), .busy, .done, .err, .ret_code);

  always @(posedge clk) if (buf_we) bmem[buf_addr] <= buf_wdata;

  int checks = 0, errors = 0, cycles = 0;
  string cur = "R1";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mprog [PDEPTH];
  int mbuf [256];
  int ms, mpc, mbr, mptr, mrpc, msub, mdc, mcnt, mtrig, mpd, mctl, mdone, merr, mcode;
  logic [31:0] mir;

  function automatic int mrd(int sel);
    return sel == 0 ? int'(pd_in) : sel == 1 ? int'(stat_in) : sel == 2 ? mctl : 0;
  endfunction

  task automatic mwr(int sel, int v);
    if (sel == 0) mpd = v & 255;
    if (sel == 2) mctl = v & 255;
  endtask

  task automatic mend(int code, int e);
    mdone = 1; mcode = code; merr = e; ms = 0;
  endtask

  task automatic mstep();
    int op, sel, a, b, c, nx, tg, st, v;
    logic [31:0] w;
    mdone = 0;
    w = (ms == 1) ? mprog[mpc] : mir;
    op = int'(w[31:27]); sel = int'(w[26:24]);
    a = int'(w[23:16]); b = int'(w[15:8]); c = int'(w[7:0]);
    st = int'(stat_in);
    case (ms)
      0: if (start) begin ms = 1; mpc = 0; msub = 0; merr = 0; mbr = 0; mptr = 0; end
      1: begin
        mir = w;
        nx = (mpc + 1) % PDEPTH;
        tg = (nx + (c > 127 ? c - 256 : c) + 256) % PDEPTH;
        mpc = nx;
        case (op)
          2:  mbuf[mptr] = mrd(sel) & a;
          3:  mwr(sel, ((sel == 2 ? mctl : mpd) | a) & ~b);
          4:  mwr(sel, a);
          5:  if (c != 0) begin mdc = c * TICKS; mtrig = 0; ms = 2; end
          6:  mbr = c;
          7:  begin mbr = (mbr + 255) % 256; if (mbr >= 1 && mbr <= 127) mpc = tg; end
          8:  if ((st & a) != 0) mpc = tg;
          9:  if ((~st & a & 255) != 0) mpc = tg;
          14: if ((st & a) == a && (st & b) == 0) mpc = tg;
          10: mend(c, 0);
          12: mptr = c;
          15: if (msub != 0) begin mpc = mrpc; msub = 0; end else mend(0, 1);
          16: if (msub == 0) begin mrpc = nx; mpc = c % PDEPTH; msub = 1; end else mend(0, 1);
          17, 18: if (a != 0) begin mcnt = a; ms = 3; end
          19: if (a != 0) begin mcnt = a; ms = 4; end
          default: mend(0, 1);
        endcase
      end
      2: if (mdc == 1) begin
           if (mtrig != 0 && mcnt != 1) begin mcnt--; ms = 4; end else ms = 1;
         end else mdc--;
      3: begin
        if (op == 17) mwr(sel, mbuf[mptr]); else mbuf[mptr] = mrd(sel) & b;
        mptr = (mptr + 1) % 256;
        if (mcnt == 1) ms = 1; else mcnt--;
      end
      4: begin mwr(sel, mbuf[mptr]); mptr = (mptr + 1) % 256; ms = 5; end
      5: begin
        v = mbuf[mptr]; mptr = (mptr + 1) % 256;
        if (v != 0) begin mdc = v * TICKS; mtrig = 1; ms = 2; end
        else if (mcnt == 1) ms = 1;
        else begin mcnt--; ms = 4; end
      end
      default: ms = 0;
    endcase
  endtask

  always @(posedge clk)
    if (!rst_n) begin
      ms = 0; mpc = 0; mbr = 0; mptr = 0; mrpc = 0; msub = 0; mdc = 0; mcnt = 0;
      mtrig = 0; mpd = 0; mctl = 0; mdone = 0; merr = 0; mcode = 0; mir = '0;
    end else mstep();

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    logic [31:0] w;
    int op, sel, ewe, ewd;
    #1;
    if (rst_n) begin
      w = (ms == 1) ? mprog[mpc] : mir;
      op = int'(w[31:27]); sel = int'(w[26:24]);
      ewe = ((ms == 1 && op == 2) || (ms == 3 && op == 18)) ? 1 : 0;
      ewd = mrd(sel) & (op == 2 ? int'(w[23:16]) : int'(w[15:8]));
      chk(busy == (ms != 0) && done == mdone[0] && err == merr[0] &&
          ret_code == mcode[7:0] && pd_out == mpd[7:0] && ctl_out == mctl[7:0] &&
          pd_oe == !mctl[5] && buf_addr == mptr[7:0] && buf_we == ewe[0] &&
          (ewe == 0 || buf_wdata == ewd[7:0]),
          cur, "cycle trace {busy,done,err,code,pd,ctl,addr,we}",
          {busy, done, err, ret_code, pd_out, ctl_out, buf_addr, buf_we},
          {ms != 0, mdone[0], merr[0], mcode[7:0], mpd[7:0], mctl[7:0], mptr[7:0], ewe[0]});
    end
  end

  function automatic logic [31:0] mi(int op, int sel, int a, int b, int c);
    return {op[4:0], sel[2:0], a[7:0], b[7:0], c[7:0]};
  endfunction

  task automatic load(int adr, logic [31:0] w);
    @(negedge clk);
    prog_we = 1; prog_addr = adr[PAW-1:0]; prog_data = w; mprog[adr] = w;
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic poke(int adr, int v);
    bmem[adr] = v[7:0]; mbuf[adr] = v;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(string req, output int code, output bit e);
    code = -1; e = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (done) begin code = ret_code; e = err; return; end
    end
    chk(0, req, "run did not finish", 0, 1);
  endtask

  task automatic run(string req, output int code, output bit e);
    cur = req;
    pulse_start();
    wait_done(req, code, e);
  endtask

  initial begin
    int code;
    bit e;
    for (int i = 0; i < 256; i++) poke(i, 0);
    for (int i = 0; i < PDEPTH; i++) mprog[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0 && done == 0 && pd_out == 0 && ctl_out == 0 && pd_oe == 1,
        "R1", "reset state", {busy, done, pd_out, ctl_out}, 0);
    rst_n = 1;

    // registers, masks, fetch, output enable
    load(0, mi(12, 0, 0, 0, 8'h10));
    load(1, mi(4, 0, 8'hA5, 0, 0));
    load(2, mi(4, 2, 8'h0F, 0, 0));
    load(3, mi(3, 2, 8'h20, 8'h01, 0));
    load(4, mi(3, 1, 8'hFF, 0, 0));
    load(5, mi(3, 0, 8'h0A, 8'hA0, 0));
    load(6, mi(2, 1, 8'hF8, 0, 0));
    load(7, mi(4, 5, 8'h99, 0, 0));
    load(8, mi(10, 0, 0, 0, 8'h33));
    run("R4", code, e);
    chk(code == 8'h33 && !e, "R9", "return code", code, 8'h33);
    chk(bmem[8'h10] == 8'h58, "R3", "fetched status byte", bmem[8'h10], 8'h58);
    chk(pd_out == 8'h0F, "R4", "modified data register", pd_out, 8'h0F);
    chk(ctl_out == 8'h2E, "R5", "control after write and modify", ctl_out, 8'h2E);
    chk(pd_oe == 0, "R14", "drive enable with direction bit set", pd_oe, 0);
    chk(buf_addr == 8'h10, "R3", "pointer unchanged by fetch", buf_addr, 8'h10);
    @(negedge clk); #1;
    chk(done == 0, "R9", "done lasts one clock", done, 0);

    // loop, delay, status branches, start while busy
    load(0, mi(6, 0, 0, 0, 3));
    load(1, mi(7, 0, 0, 0, 8'hFF));
    load(2, mi(5, 0, 0, 0, 3));
    load(3, mi(8, 0, 8'h80, 0, 1));
    load(4, mi(9, 0, 8'h80, 0, 1));
    load(5, mi(10, 0, 0, 0, 8'hE1));
    load(6, mi(14, 0, 8'h14, 8'h80, 1));
    load(7, mi(10, 0, 0, 0, 8'hE2));
    load(8, mi(7, 0, 0, 0, 1));
    load(9, mi(10, 0, 0, 0, 8'h42));
    load(10, mi(10, 0, 0, 0, 8'hE3));
    cur = "R7";
    pulse_start();
    cur = "R6";
    repeat (6) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    cur = "R8";
    wait_done("R8", code, e);
    chk(code == 8'h42, "R8", "branch path code", code, 8'h42);
    chk(code != 8'hE3, "R7", "dbra from zero falls through", code, 8'h42);

    // subroutine call and return
    load(0, mi(16, 0, 0, 0, 20));
    load(1, mi(10, 0, 0, 0, 8'h11));
    load(20, mi(4, 0, 8'h5A, 0, 0));
    load(21, mi(15, 0, 0, 0, 0));
    run("R10", code, e);
    chk(code == 8'h11 && !e, "R10", "return after subroutine", code, 8'h11);
    chk(pd_out == 8'h5A, "R10", "subroutine body ran", pd_out, 8'h5A);
    load(20, mi(16, 0, 0, 0, 30));
    run("R10", code, e);
    chk(e == 1 && code == 0, "R10", "nested call error", {e, code[7:0]}, 9'h100);
    load(0, mi(15, 0, 0, 0, 0));
    run("R10", code, e);
    chk(e == 1, "R10", "return outside subroutine error", e, 1);

    // pointer transfers and trigger pairs
    poke(8'h40, 1); poke(8'h41, 2); poke(8'h42, 3);
    poke(8'h50, 8'h81); poke(8'h51, 2); poke(8'h52, 8'h42); poke(8'h53, 0);
    load(0, mi(12, 0, 0, 0, 8'h40));
    load(1, mi(17, 0, 3, 0, 0));
    load(2, mi(18, 1, 2, 8'h0F, 0));
    load(3, mi(17, 0, 0, 0, 0));
    load(4, mi(12, 0, 0, 0, 8'h50));
    load(5, mi(19, 2, 2, 0, 0));
    load(6, mi(2, 0, 8'hFF, 0, 0));
    load(7, mi(10, 0, 0, 0, 8'h77));
    run("R12", code, e);
    chk(pd_out == 8'h03, "R12", "last byte written by repeat", pd_out, 8'h03);
    chk(bmem[8'h43] == 8'h0C && bmem[8'h44] == 8'h0C, "R12", "repeated fetch bytes",
        {bmem[8'h43], bmem[8'h44]}, 16'h0C0C);
    chk(ctl_out == 8'h42, "R13", "trigger final control", ctl_out, 8'h42);
    chk(bmem[8'h54] == 8'h3C, "R13", "pointer after two pairs", bmem[8'h54], 8'h3C);
    chk(code == 8'h77, "R2", "field layout run code", code, 8'h77);

    // unknown opcodes
    load(0, mi(13, 0, 0, 0, 8'h55));
    run("R11", code, e);
    chk(e == 1 && code == 0, "R11", "opcode 13 stops", {e, code[7:0]}, 9'h100);
    load(0, mi(25, 0, 0, 0, 8'h55));
    run("R11", code, e);
    chk(e == 1, "R11", "opcode 25 stops", e, 1);

    // start in the done clock
    load(0, mi(10, 0, 0, 0, 8'h55));
    run("R1", code, e);
    start = 1;
    @(negedge clk); start = 0; #1;
    chk(busy == 1, "R1", "restart accepted in done clock", busy, 1);
    @(negedge clk); #1;
    chk(done == 1 && ret_code == 8'h55 && err == 0, "R9", "second run done",
        {done, ret_code}, 9'h155);
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule